// File: doc/BRIEF.md
# I2C Command Queue Sequencer

This block turns packed command streams into byte-level requests for an I2C bus engine. Each bus master owns two command stores: a deep one, normally used for writes, and a shallow one, normally used for reads. Software appends 32-bit command words to a store and programs the number of words to run. It then raises that store's start bit. The sequencer walks the words in order. It latches a target address, emits start/address, write-byte and read-byte requests to the engine, and packs the returned read bytes into a per-master read buffer. It can also pulse a report flag.

Command words carry a 4-bit opcode in their low nibble. A write keeps its opcode byte and its payload bytes in the same word stream, least significant byte first, and the payload may run into later words. A read deposits a leading byte and then its payload into the read buffer, four bytes per word, least significant byte first. An engine error freezes the master until it is halted. The halt also empties its stores and its read buffer.

Top module: `i2c_cmdq_seq`

## Requirements
- R1: A load appends `cfg_wdata` to the store picked by `cfg_master`/`cfg_queue` when `cfg_kind`=0. The store of queue 0 holds 64 words and the store of queue 1 holds 16. A load into a full store, or into the store that is executing, is ignored. `q_level` slice (m*2+q) shows the stored word count, and it is 0 after reset.
- R2: Writing with `cfg_kind`=1 sets the execute count of a store. Start bit m*2+q of `q_start` runs exactly that many words from the first word. Words beyond the count are never decoded. When the run ends, the store's `q_level` returns to 0.
- R3: Opcode 1 (bits 3:0) latches a 7-bit target address from bits 10:4. A transfer begins with an engine request whose op is 0 (start, write) or 1 (start, read) and whose byte is {address, 0} or {address, 1}.
- R4: Opcode 9 is a write, with its byte length in bits 7:4. The payload bytes follow the opcode byte in the same word, least significant byte first, and they continue into the next words. Each payload byte becomes one engine request with op 2. `eng_req_last` is 1 on the final request of the transfer; for a zero-length write this is the start request. The next command begins at the next word boundary.
- R5: Opcode 10 is a read, with its byte length N in bits 11:4. It issues N engine requests with op 3, the last one flagged. The read buffer gains N/4+1 words. Byte 0 of the first word is {address, 1}, the received bytes follow least significant byte first, and unused bytes are 0. `rd_done` pulses once per read.
- R6: Opcode 8 with bit 8 set pulses `rep_pulse` bit m*2+q for one cycle. With bit 8 clear it has no effect.
- R7: Any other opcode is skipped as a one-word no-op and issues no engine request.
- R8: An engine response with `eng_rsp_err` set raises `bus_err` for that master. The master stops issuing requests and keeps its stored words until `halt` is pulsed. A halt clears the error, empties both stores and empties the read buffer.
- R9: When both stores of a master are started together, queue 0 runs to completion before queue 1.
- R10: An engine request keeps its op, byte and last flag unchanged until the cycle in which it is answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register-style write strobe |
| cfg_kind | input | 1 | 0: append command word, 1: set execute count |
| cfg_master | input | 1 | Master selector |
| cfg_queue | input | 1 | Queue selector |
| cfg_wdata | input | 32 | Command word or execute count |
| q_start | input | 4 | Start bits, index master*2+queue |
| halt | input | 2 | Per-master halt and flush |
| q_level | output | 28 | Stored word count per store, 7 bits each, index master*2+queue |
| eng_req_valid | output | 2 | Engine request pending, per master |
| eng_req_op | output | 4 | Request op per master: 0 start-write, 1 start-read, 2 write byte, 3 read byte |
| eng_req_byte | output | 16 | Address or data byte per master |
| eng_req_last | output | 2 | Final request of the transfer |
| eng_rsp_valid | input | 2 | Engine answers the pending request |
| eng_rsp_byte | input | 16 | Received byte for read requests |
| eng_rsp_err | input | 2 | NACK or bus error with the answer |
| rd_pop | input | 1 | Pop one word from the selected read buffer |
| rd_master | input | 1 | Read buffer selector |
| rd_word | output | 32 | Head word of the selected read buffer |
| rd_level | output | 6 | Read buffer word count per master, 3 bits each |
| rep_pulse | output | 4 | Report pulse, index master*2+queue |
| rd_done | output | 2 | Read completed pulse per master |
| bus_err | output | 2 | Sticky engine error per master |

## Verification
The bench targets the points where a packed stream is easy to misparse. These are a write whose payload crosses into a second word, a zero-length write and a run whose count stops short of the stored words. A decoder that did not restart at the word boundary after a write would read padding as an opcode and issue stray requests. A decoder that ignored the count would execute the trailing word. A read of six bytes must leave exactly two buffer words with the leading byte in the lowest lane. An off-by-one packer would show up as a wrong level or as shifted bytes. The bench also starts both queues together to check that queue 0 goes first, and it injects an engine error to confirm that the master goes silent, keeps its words and recovers only on halt. It fills the shallow queue past its capacity and starts the second master to check the start-bit indexing.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;
  localparam logic [3:0] OPC_SETP   = 4'd1;
  localparam logic [3:0] OPC_REPORT = 4'd8;
  localparam logic [3:0] OPC_WRITE  = 4'd9;
  localparam logic [3:0] OPC_READ   = 4'd10;

  typedef enum logic [1:0] {
    ENG_START_WR = 2'd0,
    ENG_START_RD = 2'd1,
    ENG_WRITE    = 2'd2,
    ENG_READ     = 2'd3
  } eng_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_DEC, S_BUS, S_WB, S_RB, S_ERR
  } seq_st_e;

  typedef enum logic [1:0] {
    K_WR, K_RA, K_RB
  } xfer_kind_e;
endpackage

// File: rtl/i2cq_cmd_store.sv
module i2cq_cmd_store #(
  parameter int DEPTH = 64,
  parameter int CW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [31:0]   ld_word,
  input  logic          clr,
  input  logic [CW-1:0] rd_idx,
  output logic [31:0]   rd_word,
  output logic [CW-1:0] level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [31:0]   mem [DEPTH];
  logic [CW-1:0] lvl_q, lvl_d;
  logic          wr_ok;

  assign wr_ok = ld_en && !clr && (lvl_q < CW'(DEPTH));

  always_comb begin
    lvl_d = lvl_q;
    if (clr)        lvl_d = '0;
    else if (wr_ok) lvl_d = lvl_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_d;
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[lvl_q[AW-1:0]] <= ld_word;
  end

  assign rd_word = (rd_idx < CW'(DEPTH)) ? mem[rd_idx[AW-1:0]] : '0;
  assign level   = lvl_q;

  p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= CW'(DEPTH));
  p_clear_empties_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> lvl_q == '0);
endmodule

// File: rtl/i2cq_rd_pack.sv
module i2cq_rd_pack #(
  parameter int WORDS = 4,
  parameter int LW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          b_valid,
  input  logic [7:0]    b_data,
  input  logic          flush,
  input  logic          pop,
  output logic [31:0]   head,
  output logic [LW-1:0] level
);
  localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [31:0]   mem [WORDS];
  logic [31:0]   acc_q, acc_d, merged;
  logic [1:0]    pos_q, pos_d;
  logic [AW-1:0] wp_q, rp_q;
  logic [LW-1:0] lvl_q, lvl_d;
  logic          push, push_ok, pop_ok;

  always_comb begin
    merged = acc_q;
    if (b_valid) merged[{pos_q, 3'b000} +: 8] = b_data;
    push    = (b_valid && (pos_q == 2'd3 || flush)) ||
              (!b_valid && flush && pos_q != 2'd0);
    push_ok = push && !clr && (lvl_q < LW'(WORDS));
    pop_ok  = pop && !clr && (lvl_q != '0);
    pos_d   = pos_q;
    acc_d   = merged;
    if (clr || push) begin
      pos_d = 2'd0;
      acc_d = '0;
    end else if (b_valid) begin
      pos_d = pos_q + 2'd1;
    end
    lvl_d = lvl_q;
    if (clr) lvl_d = '0;
    else if (push_ok && !pop_ok) lvl_d = lvl_q + LW'(1);
    else if (!push_ok && pop_ok) lvl_d = lvl_q - LW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      pos_q <= '0;
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      acc_q <= acc_d;
      pos_q <= pos_d;
      lvl_q <= lvl_d;
      if (clr) begin
        wp_q <= '0;
        rp_q <= '0;
      end else begin
        if (push_ok) wp_q <= (wp_q == AW'(WORDS - 1)) ? '0 : wp_q + AW'(1);
        if (pop_ok)  rp_q <= (rp_q == AW'(WORDS - 1)) ? '0 : rp_q + AW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q] <= merged;
  end

  assign head  = mem[rp_q];
  assign level = lvl_q;

  p_rb_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LW'(WORDS));
endmodule

// File: rtl/i2cq_master.sv
module i2cq_master
  import i2cq_pkg::*;
#(
  parameter int WQ_DEPTH = 64,
  parameter int RQ_DEPTH = 16,
  parameter int CW       = 7,
  parameter int RB_WORDS = 4,
  parameter int RLW      = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_en,
  input  logic            ld_q,
  input  logic [31:0]     ld_word,
  input  logic            xc_en,
  input  logic            xc_q,
  input  logic [CW-1:0]   xc_val,
  input  logic [1:0]      start,
  input  logic            halt,
  output logic [2*CW-1:0] levels,
  output logic            eng_req_valid,
  output logic [1:0]      eng_req_op,
  output logic [7:0]      eng_req_byte,
  output logic            eng_req_last,
  input  logic            eng_rsp_valid,
  input  logic [7:0]      eng_rsp_byte,
  input  logic            eng_rsp_err,
  input  logic            rd_pop,
  output logic [31:0]     rd_head,
  output logic [RLW-1:0]  rd_level,
  output logic [1:0]      rep,
  output logic            rd_done,
  output logic            bus_err
);
  seq_st_e    st_q, st_d;
  xfer_kind_e kind_q, kind_d;
  logic          cur_q, cur_d;
  logic [CW-1:0] widx_q, widx_d, left_q, left_d, left_after;
  logic [1:0]    bp_q, bp_d, pend_q, pend_d, rep_q, rep_d, qclr;
  logic [7:0]    cnt_q, cnt_d, byte_q, byte_d;
  logic [6:0]    addr_q, addr_d;
  eng_op_e       op_q, op_d;
  logic          last_q, last_d, done_q, done_d, err_q, err_d;
  logic          do_adv, do_end, rb_bval, rb_flush;
  logic [7:0]    rb_byte;
  logic [CW-1:0] xcnt_q [2];
  logic [31:0]   qword [2];
  logic [CW-1:0] lvl [2];
  logic [31:0]   word;

  for (genvar gq = 0; gq < 2; gq++) begin : g_q
    localparam int D = (gq == 0) ? WQ_DEPTH : RQ_DEPTH;
    logic ld_this;
    assign ld_this = ld_en && (ld_q == 1'(gq)) &&
                     !(st_q != S_IDLE && cur_q == 1'(gq));
    i2cq_cmd_store #(.DEPTH(D), .CW(CW)) u_store (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_this), .ld_word(ld_word),
      .clr(qclr[gq]), .rd_idx(widx_q), .rd_word(qword[gq]), .level(lvl[gq])
    );
    assign levels[gq*CW +: CW] = lvl[gq];
  end

  i2cq_rd_pack #(.WORDS(RB_WORDS), .LW(RLW)) u_pack (
    .clk(clk), .rst_n(rst_n), .clr(halt), .b_valid(rb_bval), .b_data(rb_byte),
    .flush(rb_flush), .pop(rd_pop), .head(rd_head), .level(rd_level)
  );

  assign word = qword[cur_q];

  always_comb begin
    st_d = st_q;  kind_d = kind_q;  cur_d = cur_q;
    widx_d = widx_q;  left_d = left_q;  bp_d = bp_q;
    cnt_d = cnt_q;  addr_d = addr_q;  op_d = op_q;
    byte_d = byte_q;  last_d = last_q;  err_d = err_q;
    pend_d = pend_q | start;
    rep_d = 2'b00;  done_d = 1'b0;  qclr = 2'b00;
    do_adv = 1'b0;  do_end = 1'b0;  left_after = left_q;
    rb_bval = 1'b0;  rb_byte = 8'h00;  rb_flush = 1'b0;
    unique case (st_q)
      S_IDLE: if (pend_q != 2'b00) begin
        cur_d = pend_q[0] ? 1'b0 : 1'b1;
        pend_d[cur_d] = 1'b0;
        widx_d = '0;
        bp_d   = 2'd0;
        left_d = xcnt_q[cur_d];
        if (xcnt_q[cur_d] == '0) qclr[cur_d] = 1'b1;
        else st_d = S_DEC;
      end
      S_DEC: begin
        case (word[3:0])
          OPC_SETP: begin
            addr_d = word[10:4];
            do_adv = 1'b1;
          end
          OPC_REPORT: begin
            rep_d[cur_q] = word[8];
            do_adv = 1'b1;
          end
          OPC_WRITE: begin
            cnt_d  = {4'h0, word[7:4]};
            bp_d   = 2'd1;
            op_d   = ENG_START_WR;
            byte_d = {addr_q, 1'b0};
            last_d = (word[7:4] == 4'h0);
            kind_d = K_WR;
            st_d   = S_BUS;
          end
          OPC_READ: begin
            cnt_d   = word[11:4];
            op_d    = ENG_START_RD;
            byte_d  = {addr_q, 1'b1};
            last_d  = (word[11:4] == 8'h00);
            kind_d  = K_RA;
            rb_bval = 1'b1;
            rb_byte = {addr_q, 1'b1};
            st_d    = S_BUS;
          end
          default: do_adv = 1'b1;
        endcase
      end
      S_BUS: if (eng_rsp_valid) begin
        if (eng_rsp_err) begin
          err_d = 1'b1;
          st_d  = S_ERR;
        end else begin
          unique case (kind_q)
            K_WR: begin
              if (cnt_q != 8'h00)     st_d = S_WB;
              else if (bp_q == 2'd0)  do_end = 1'b1;
              else                    do_adv = 1'b1;
            end
            K_RA: begin
              if (cnt_q != 8'h00) st_d = S_RB;
              else begin
                rb_flush = 1'b1;
                done_d   = 1'b1;
                do_adv   = 1'b1;
              end
            end
            default: begin
              rb_bval = 1'b1;
              rb_byte = eng_rsp_byte;
              if (cnt_q != 8'h00) st_d = S_RB;
              else begin
                rb_flush = 1'b1;
                done_d   = 1'b1;
                do_adv   = 1'b1;
              end
            end
          endcase
        end
      end
      S_WB: begin
        op_d   = ENG_WRITE;
        byte_d = word[{bp_q, 3'b000} +: 8];
        last_d = (cnt_q == 8'h01);
        cnt_d  = cnt_q - 8'h01;
        bp_d   = bp_q + 2'd1;
        if (bp_q == 2'd3) begin
          widx_d = widx_q + CW'(1);
          left_d = (left_q != '0) ? left_q - CW'(1) : '0;
        end
        st_d = S_BUS;
      end
      S_RB: begin
        op_d   = ENG_READ;
        byte_d = 8'h00;
        last_d = (cnt_q == 8'h01);
        cnt_d  = cnt_q - 8'h01;
        kind_d = K_RB;
        st_d   = S_BUS;
      end
      default: ;
    endcase
    if (do_adv || do_end) begin
      if (do_adv) begin
        widx_d     = widx_q + CW'(1);
        left_after = (left_q != '0) ? left_q - CW'(1) : '0;
      end
      left_d = left_after;
      if (left_after == '0) begin
        st_d        = S_IDLE;
        qclr[cur_q] = 1'b1;
      end else begin
        st_d = S_DEC;
      end
    end
    if (halt) begin
      st_d   = S_IDLE;
      pend_d = 2'b00;
      err_d  = 1'b0;
      qclr   = 2'b11;
      rep_d  = 2'b00;
      done_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;  kind_q <= K_WR;  cur_q <= 1'b0;
      widx_q <= '0;  left_q <= '0;  bp_q <= '0;  cnt_q <= '0;
      addr_q <= '0;  op_q <= ENG_START_WR;  byte_q <= '0;  last_q <= 1'b0;
      pend_q <= '0;  rep_q <= '0;  done_q <= 1'b0;  err_q <= 1'b0;
    end else begin
      st_q <= st_d;  kind_q <= kind_d;  cur_q <= cur_d;
      widx_q <= widx_d;  left_q <= left_d;  bp_q <= bp_d;  cnt_q <= cnt_d;
      addr_q <= addr_d;  op_q <= op_d;  byte_q <= byte_d;  last_q <= last_d;
      pend_q <= pend_d;  rep_q <= rep_d;  done_q <= done_d;  err_q <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xcnt_q[0] <= '0;
      xcnt_q[1] <= '0;
    end else if (xc_en) begin
      xcnt_q[xc_q] <= xc_val;
    end
  end

  assign eng_req_valid = (st_q == S_BUS);
  assign eng_req_op    = op_q;
  assign eng_req_byte  = byte_q;
  assign eng_req_last  = last_q;
  assign rep           = rep_q;
  assign rd_done       = done_q;
  assign bus_err       = err_q;

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req_valid && !eng_rsp_valid && !halt |=> eng_req_valid &&
    $stable(eng_req_op) && $stable(eng_req_byte) && $stable(eng_req_last));
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err && !halt |=> bus_err);
  p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> !eng_req_valid);
  p_halt_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !bus_err && levels == '0);
  p_rep_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rep));
endmodule

// File: rtl/i2c_cmdq_seq.sv
module i2c_cmdq_seq #(
  parameter int MASTERS  = 2,
  parameter int WQ_DEPTH = 64,
  parameter int RQ_DEPTH = 16,
  parameter int RB_WORDS = 4,
  localparam int MW  = (MASTERS > 1) ? $clog2(MASTERS) : 1,
  localparam int CW  = $clog2(((WQ_DEPTH > RQ_DEPTH) ? WQ_DEPTH : RQ_DEPTH) + 1),
  localparam int RLW = $clog2(RB_WORDS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic                   cfg_kind,
  input  logic [MW-1:0]          cfg_master,
  input  logic                   cfg_queue,
  input  logic [31:0]            cfg_wdata,
  input  logic [2*MASTERS-1:0]   q_start,
  input  logic [MASTERS-1:0]     halt,
  output logic [2*MASTERS*CW-1:0] q_level,
  output logic [MASTERS-1:0]     eng_req_valid,
  output logic [2*MASTERS-1:0]   eng_req_op,
  output logic [8*MASTERS-1:0]   eng_req_byte,
  output logic [MASTERS-1:0]     eng_req_last,
  input  logic [MASTERS-1:0]     eng_rsp_valid,
  input  logic [8*MASTERS-1:0]   eng_rsp_byte,
  input  logic [MASTERS-1:0]     eng_rsp_err,
  input  logic                   rd_pop,
  input  logic [MW-1:0]          rd_master,
  output logic [31:0]            rd_word,
  output logic [MASTERS*RLW-1:0] rd_level,
  output logic [2*MASTERS-1:0]   rep_pulse,
  output logic [MASTERS-1:0]     rd_done,
  output logic [MASTERS-1:0]     bus_err
);
  logic [1:0]  rs_q;
  logic        rst_s_n;
  logic [31:0] heads [MASTERS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  for (genvar gm = 0; gm < MASTERS; gm++) begin : g_m
    logic sel;
    assign sel = cfg_we && (cfg_master == MW'(gm));
    i2cq_master #(
      .WQ_DEPTH(WQ_DEPTH), .RQ_DEPTH(RQ_DEPTH), .CW(CW),
      .RB_WORDS(RB_WORDS), .RLW(RLW)
    ) u_master (
      .clk(clk), .rst_n(rst_s_n),
      .ld_en(sel && !cfg_kind), .ld_q(cfg_queue), .ld_word(cfg_wdata),
      .xc_en(sel && cfg_kind), .xc_q(cfg_queue), .xc_val(cfg_wdata[CW-1:0]),
      .start(q_start[2*gm +: 2]), .halt(halt[gm]),
      .levels(q_level[2*gm*CW +: 2*CW]),
      .eng_req_valid(eng_req_valid[gm]), .eng_req_op(eng_req_op[2*gm +: 2]),
      .eng_req_byte(eng_req_byte[8*gm +: 8]), .eng_req_last(eng_req_last[gm]),
      .eng_rsp_valid(eng_rsp_valid[gm]), .eng_rsp_byte(eng_rsp_byte[8*gm +: 8]),
      .eng_rsp_err(eng_rsp_err[gm]),
      .rd_pop(rd_pop && (rd_master == MW'(gm))), .rd_head(heads[gm]),
      .rd_level(rd_level[RLW*gm +: RLW]),
      .rep(rep_pulse[2*gm +: 2]), .rd_done(rd_done[gm]), .bus_err(bus_err[gm])
    );
  end

  assign rd_word = heads[rd_master];
endmodule

// File: tb/tb_i2c_cmdq_seq.sv
`timescale 1ns/1ps
module tb_i2c_cmdq_seq;
  localparam int M = 2, CW = 7, RLW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_kind = 1'b0, cfg_queue = 1'b0;
  logic [0:0] cfg_master = '0, rd_master = '0;
  logic [31:0] cfg_wdata = '0;
  logic [3:0] q_start = '0;
  logic [1:0] halt = '0;
  logic [2*M*CW-1:0] q_level;
  logic [1:0] eng_req_valid, eng_req_last, bus_err, rd_done;
  logic [3:0] eng_req_op, rep_pulse;
  logic [15:0] eng_req_byte;
  logic [1:0] rspv = '0, rsperr = '0;
  logic [15:0] rspb = '0;
  logic rd_pop = 1'b0;
  logic [31:0] rd_word;
  logic [M*RLW-1:0] rd_level;

  i2c_cmdq_seq dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_master(cfg_master), .cfg_queue(cfg_queue), .cfg_wdata(cfg_wdata),
    .q_start(q_start), .halt(halt), .q_level(q_level),
    .eng_req_valid(eng_req_valid), .eng_req_op(eng_req_op),
    .eng_req_byte(eng_req_byte), .eng_req_last(eng_req_last),
    .eng_rsp_valid(rspv), .eng_rsp_byte(rspb), .eng_rsp_err(rsperr),
    .rd_pop(rd_pop), .rd_master(rd_master), .rd_word(rd_word),
    .rd_level(rd_level), .rep_pulse(rep_pulse), .rd_done(rd_done),
    .bus_err(bus_err)
  );

  always #2.5 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit finished = 0;
  logic [11:0] sbq[$];
  logic [11:0] seen [2];
  int wt [2];
  logic [1:0] inj = '0;
  logic [7:0] rdb = 8'h00;
  int repcnt [4];
  int donecnt [2];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  // Scoreboard monitor / engine model: compares each request to the expected queue
  always @(negedge clk) begin
    for (int m = 0; m < 2; m++) begin
      if (rspv[m]) begin
        rspv[m] = 1'b0;
        rsperr[m] = 1'b0;
        wt[m] = 0;
      end else if (eng_req_valid[m]) begin
        logic [11:0] cur;
        cur = {1'(m), eng_req_op[2*m +: 2], eng_req_last[m], eng_req_byte[8*m +: 8]};
        if (wt[m] == 0) begin
          if (sbq.size() == 0) chk("R2/R7 unexpected request", {20'h0, cur}, 32'hFFF);
          else chk("R3/R4/R5/R9 request order", {20'h0, cur}, {20'h0, sbq.pop_front()});
          seen[m] = cur;
          wt[m] = 1;
        end else begin
          chk("R10 request held", {20'h0, cur}, {20'h0, seen[m]});
          if (wt[m] == 2) begin
            rspv[m] = 1'b1;
            rsperr[m] = inj[m];
            inj[m] = 1'b0;
            if (eng_req_op[2*m +: 2] == 2'd3) begin
              rspb[8*m +: 8] = rdb;
              rdb = rdb + 8'h01;
            end else rspb[8*m +: 8] = 8'h00;
          end
          wt[m] = wt[m] + 1;
        end
      end
    end
    for (int b = 0; b < 4; b++) if (rep_pulse[b]) repcnt[b]++;
    for (int m = 0; m < 2; m++) if (rd_done[m]) donecnt[m]++;
  end

  function automatic logic [6:0] lvl(input int m, input int q);
    return q_level[(m*2+q)*CW +: CW];
  endfunction

  task automatic cfg(input logic kind, input int m, input int q, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = kind; cfg_master = 1'(m); cfg_queue = 1'(q); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic kick(input logic [3:0] v);
    @(negedge clk); q_start = v;
    @(negedge clk); q_start = '0;
  endtask

  task automatic do_halt(input logic [1:0] v);
    @(negedge clk); halt = v;
    @(negedge clk); halt = '0;
  endtask

  task automatic expect_req(input int m, input logic [1:0] op, input logic last, input logic [7:0] b);
    sbq.push_back({1'(m), op, last, b});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pop_chk(input int m, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_master = 1'(m);
    #1;
    chk(tag, rd_word, exp);
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) repcnt[i] = 0;
    for (int i = 0; i < 2; i++) begin donecnt[i] = 0; wt[i] = 0; end
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    chk("R1 reset levels", {4'h0, q_level}, 32'h0);
    chk("R8 reset bus_err", {30'h0, bus_err}, 32'h0);
    chk("R5 reset read level", {26'h0, rd_level}, 32'h0);

    // R4 write spanning two words, R6 report with bit 8
    cfg(0, 0, 0, 32'h0000_0351);
    cfg(0, 0, 0, 32'h3322_1159);
    cfg(0, 0, 0, 32'h0000_5544);
    cfg(0, 0, 0, 32'h0000_0108);
    chk("R1 level after four loads", lvl(0, 0), 4);
    cfg(1, 0, 0, 4);
    expect_req(0, 2'd0, 1'b0, 8'h6A);
    expect_req(0, 2'd2, 1'b0, 8'h11);
    expect_req(0, 2'd2, 1'b0, 8'h22);
    expect_req(0, 2'd2, 1'b0, 8'h33);
    expect_req(0, 2'd2, 1'b0, 8'h44);
    expect_req(0, 2'd2, 1'b1, 8'h55);
    kick(4'b0001);
    idle(150);
    chk("R6 report pulse q0", repcnt[0], 1);
    chk("R2 level cleared after run", lvl(0, 0), 0);

    // R5 read of six bytes on queue 1, R6 report without bit 8
    cfg(0, 0, 1, 32'h0000_0211);
    cfg(0, 0, 1, 32'h0000_006A);
    cfg(0, 0, 1, 32'h0000_0008);
    cfg(1, 0, 1, 3);
    rdb = 8'hC0;
    expect_req(0, 2'd1, 1'b0, 8'h43);
    for (int i = 0; i < 6; i++) expect_req(0, 2'd3, (i == 5), 8'h00);
    kick(4'b0010);
    idle(150);
    chk("R6 no report without bit 8", repcnt[1], 0);
    chk("R5 read-done pulse", donecnt[0], 1);
    chk("R5 buffer words N/4+1", rd_level[0 +: RLW], 2);
    pop_chk(0, 32'hC2C1_C043, "R5 first read word");
    pop_chk(0, 32'h00C5_C4C3, "R5 second read word");
    chk("R5 buffer empty after pops", rd_level[0 +: RLW], 0);

    // R7 unknown opcode, zero-length write, R2 count stops before last word
    cfg(0, 0, 0, 32'h0000_000F);
    cfg(0, 0, 0, 32'h0000_0101);
    cfg(0, 0, 0, 32'h0000_0009);
    cfg(0, 0, 0, 32'h0000_EE19);
    cfg(1, 0, 0, 3);
    expect_req(0, 2'd0, 1'b1, 8'h20);
    kick(4'b0001);
    idle(100);
    chk("R2 trailing word dropped", lvl(0, 0), 0);
    chk("R2 all expected requests seen", sbq.size(), 0);

    // R9 both queues started together
    cfg(0, 0, 0, 32'h0000_0111);
    cfg(0, 0, 0, 32'h0000_AB19);
    cfg(1, 0, 0, 2);
    cfg(0, 0, 1, 32'h0000_0121);
    cfg(0, 0, 1, 32'h0000_000A);
    cfg(1, 0, 1, 2);
    expect_req(0, 2'd0, 1'b0, 8'h22);
    expect_req(0, 2'd2, 1'b1, 8'hAB);
    expect_req(0, 2'd1, 1'b1, 8'h25);
    kick(4'b0011);
    idle(150);
    chk("R9 queue 0 then queue 1 done", sbq.size(), 0);
    chk("R5 zero-length read one word", rd_level[0 +: RLW], 1);
    pop_chk(0, 32'h0000_0025, "R5 zero-length read lead byte");

    // R2 start index m*2+q on master 1
    cfg(0, 1, 0, 32'h0000_07F1);
    cfg(0, 1, 0, 32'h0002_0129);
    cfg(0, 1, 0, 32'h0000_0108);
    cfg(1, 1, 0, 3);
    expect_req(1, 2'd0, 1'b0, 8'hFE);
    expect_req(1, 2'd2, 1'b0, 8'h01);
    expect_req(1, 2'd2, 1'b1, 8'h02);
    kick(4'b0100);
    idle(120);
    chk("R2 master 1 run complete", sbq.size(), 0);
    chk("R6 report bit 2", repcnt[2], 1);
    chk("R2 master 0 untouched", repcnt[0], 1);

    // R1 overfill shallow queue, R8 halt flushes
    for (int i = 0; i < 17; i++) cfg(0, 0, 1, 32'h0000_000F);
    chk("R1 shallow queue caps at 16", lvl(0, 1), 16);
    do_halt(2'b01);
    idle(2);
    chk("R8 halt empties queue", lvl(0, 1), 0);

    // R8 engine error
    cfg(0, 0, 0, 32'h0000_0051);
    cfg(0, 0, 0, 32'h00BB_AA29);
    cfg(0, 0, 0, 32'h0000_0108);
    cfg(1, 0, 0, 3);
    expect_req(0, 2'd0, 1'b0, 8'h0A);
    inj[0] = 1'b1;
    kick(4'b0001);
    idle(80);
    chk("R8 bus_err raised", {31'h0, bus_err[0]}, 1);
    chk("R8 no report after error", repcnt[0], 1);
    chk("R8 words kept while stopped", lvl(0, 0), 3);
    chk("R8 no request after error", {31'h0, eng_req_valid[0]}, 0);
    do_halt(2'b01);
    idle(2);
    chk("R8 halt clears error", {31'h0, bus_err[0]}, 0);
    chk("R8 halt clears queue", lvl(0, 0), 0);
    chk("R2 scoreboard drained", sbq.size(), 0);
    summary();
  end
endmodule